// File: doc/BRIEF.md
# Alternating-Polarity Ripple-Carry Adder

This block adds two unsigned operands and a carry-in, producing a sum vector and a final carry-out. It is a ripple-carry adder assembled from one full-adder cell per bit position. The carry that travels between cells alternates in polarity from one position to the next, so the chain never needs an inverter between neighbouring cells.

Cells at even positions receive true operands and a true incoming carry, and they hand on a complemented carry. Cells at odd positions receive complemented operands and the complemented carry from their neighbour. Because inverting every input of a full adder inverts both of its outputs, an odd cell hands on a carry in true polarity. Each cell sorts its operand pair into one of three classes: generate (both ones), propagate (operands differ) or delete (both zeros). The propagate term decides whether the cell's sum bit is the incoming carry or its complement. At the block edge, odd-cell sum bits are flipped back locally. The final carry is restored to true polarity whenever the chain ends on an even cell. The block is purely combinational, and its width is a parameter that may be odd or even.

Top module: `alt_ripple_adder`

## Requirements
- R1: For every operand pair and carry-in, {carry_out, sum} equals op_a + op_b + carry_in, taken as an unsigned value one bit wider than the operands.
- R2: Every sum bit, at odd and at even positions, is in true polarity and equals op_a[k] xor op_b[k] xor (carry into position k).
- R3: A position where both operand bits are 1 (generate) sends a carry of 1 into the next position, whatever carry it receives.
- R4: A position where both operand bits are 0 (delete) sends a carry of 0 into the next position, whatever carry it receives.
- R5: A position where the operand bits differ (propagate) passes on the carry it receives unchanged. With op_a = ~op_b across the whole word, sum is all ones and carry_out is 0 when carry_in is 0; sum is all zeros and carry_out is 1 when carry_in is 1.
- R6: Each position falls into exactly one of the generate, propagate and delete classes.
- R7: carry_out is in true polarity for both odd and even values of WIDTH.
- R8: The outputs depend only on the present inputs. No clock edge is needed between an input change and the matching result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand, unsigned |
| op_b | input | WIDTH | Second operand, unsigned |
| carry_in | input | 1 | Carry into bit 0, true polarity |
| sum | output | WIDTH | Sum vector, true polarity in every bit |
| carry_out | output | 1 | Carry out of the top bit, true polarity |

## Verification
The bench builds three copies of the block. The first has WIDTH=4 and the second WIDTH=5; both are driven through every operand and carry-in combination. The odd width makes the chain end on an even cell, which exercises the final carry correction, while the even width ends on an odd cell. The third copy uses the default WIDTH=16 and receives seeded random operands together with directed cases. These directed cases cover the full propagate ripple, isolated generate and delete positions, and the all-ones and all-zeros words. All of these are sampled without any clock edge between stimulus and check.

// File: rtl/alt_adder_pkg.sv
package alt_adder_pkg;

    // Classification of one operand pair
    typedef struct packed {
        logic gen;   // both ones
        logic prop;  // operands differ
        logic del;   // both zeros
    } pair_class_t;

    function automatic pair_class_t classify_pair(input logic x, input logic y);
        pair_class_t c;
        c.gen  = x & y;
        c.prop = x ^ y;
        c.del  = ~x & ~y;
        return c;
    endfunction

endpackage

// File: rtl/alt_fa_core.sv
// Full-adder core with complemented carry output.
module alt_fa_core
    import alt_adder_pkg::*;
(
    input  logic x_in,
    input  logic y_in,
    input  logic cy_in,
    output logic sum_out,
    output logic cy_out_n
);

    pair_class_t cls_d;

    always_comb begin
        cls_d    = classify_pair(x_in, y_in);
        // propagate selects between true and complemented incoming carry
        sum_out  = cls_d.prop ? ~cy_in : cy_in;
        // complemented carry: pass on inverted carry, else the delete term
        cy_out_n = cls_d.prop ? ~cy_in : cls_d.del;

        AST_ONE_CLASS: assert ($onehot({cls_d.gen, cls_d.prop, cls_d.del}))
            else $error("pair class not unique"); // R6
        AST_SUM_PARITY: assert (sum_out == (x_in ^ y_in ^ cy_in))
            else $error("sum bit parity wrong"); // R2
        if (cls_d.gen) begin
            AST_GEN_CARRY: assert (cy_out_n == 1'b0)
                else $error("generate did not set carry"); // R3
        end
        if (cls_d.del) begin
            AST_DEL_KILL: assert (cy_out_n == 1'b1)
                else $error("delete did not kill carry"); // R4
        end
        if (cls_d.prop) begin
            AST_PROP_PASS: assert (cy_out_n == ~cy_in)
                else $error("propagate did not pass carry"); // R5
        end
    end

endmodule

// File: rtl/alt_parity_slice.sv
// One bit slice; ODD_POS selects the complemented-input variant.
module alt_parity_slice #(
    parameter bit ODD_POS = 1'b0
) (
    input  logic a_bit,
    input  logic b_bit,
    input  logic cy_in,     // true at even positions, complemented at odd
    output logic sum_bit,   // always true polarity
    output logic cy_out     // opposite polarity to cy_in
);

    logic core_x_d, core_y_d, core_sum_d, core_cy_n_d;

    generate
        if (ODD_POS) begin : g_odd
            // operands enter inverted; inversion property keeps the chain correct
            always_comb begin
                core_x_d = ~a_bit;
                core_y_d = ~b_bit;
                sum_bit  = ~core_sum_d;
            end
        end else begin : g_even
            always_comb begin
                core_x_d = a_bit;
                core_y_d = b_bit;
                sum_bit  = core_sum_d;
            end
        end
    endgenerate

    alt_fa_core i_core (
        .x_in    (core_x_d),
        .y_in    (core_y_d),
        .cy_in   (cy_in),
        .sum_out (core_sum_d),
        .cy_out_n(core_cy_n_d)
    );

    assign cy_out = core_cy_n_d;

endmodule

// File: rtl/alt_ripple_adder.sv
module alt_ripple_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    // chain end polarity: true when the last cell is odd
    localparam bit LAST_ODD = ((WIDTH - 1) % 2) == 1;

    logic [WIDTH:0] chain_d;

    assign chain_d[0] = carry_in;

    generate
        for (genvar k = 0; k < WIDTH; k++) begin : g_bit
            alt_parity_slice #(
                .ODD_POS((k % 2) == 1)
            ) i_slice (
                .a_bit  (op_a[k]),
                .b_bit  (op_b[k]),
                .cy_in  (chain_d[k]),
                .sum_bit(sum[k]),
                .cy_out (chain_d[k+1])
            );
        end
        if (LAST_ODD) begin : g_out_true
            assign carry_out = chain_d[WIDTH];
        end else begin : g_out_fix
            assign carry_out = ~chain_d[WIDTH];
        end
    endgenerate

endmodule

// File: tb/test_alt_ripple_adder.sv
module test_alt_ripple_adder;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // DUT copies
    logic [15:0] a16, b16, s16;  logic c16, co16;
    logic [3:0]  a4, b4, s4;     logic c4, co4;
    logic [4:0]  a5, b5, s5;     logic c5, co5;

    alt_ripple_adder #(.WIDTH(16)) i_alt_ripple_adder (
        .op_a(a16), .op_b(b16), .carry_in(c16), .sum(s16), .carry_out(co16));
    alt_ripple_adder #(.WIDTH(4)) i_alt_ripple_adder_w4 (
        .op_a(a4), .op_b(b4), .carry_in(c4), .sum(s4), .carry_out(co4));
    alt_ripple_adder #(.WIDTH(5)) i_alt_ripple_adder_w5 (
        .op_a(a5), .op_b(b5), .carry_in(c5), .sum(s5), .carry_out(co5));

    function automatic logic [16:0] ref_add16(input logic [15:0] x, input logic [15:0] y, input logic ci);
        return {1'b0, x} + {1'b0, y} + {16'd0, ci};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run16(input logic [15:0] x, input logic [15:0] y, input logic ci, input string req);
        logic [16:0] e;
        @(negedge clk);
        a16 = x; b16 = y; c16 = ci;
        #1;   // no clock edge in between: R8
        e = ref_add16(x, y, ci);
        check({co16, s16} == e, req, {15'd0, co16, s16}, {15'd0, e});
        // R2: odd-position bits in true polarity
        check((s16 & 16'hAAAA) == (e[15:0] & 16'hAAAA), "R2", {16'd0, s16 & 16'hAAAA}, {16'd0, e[15:0] & 16'hAAAA});
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [16:0] e;
        a16 = '0; b16 = '0; c16 = 1'b0;
        a4 = '0; b4 = '0; c4 = 1'b0;
        a5 = '0; b5 = '0; c5 = 1'b0;
        #1;
        // initial all-zero inputs give zero result
        check({co16, s16} == 17'd0, "R1", {15'd0, co16, s16}, 32'd0);

        // exhaustive WIDTH=4 (chain ends on odd cell): R1, R7
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            {c4, a4, b4} = 9'(i);
            #1;
            e = {12'd0, 1'b0, a4} + {12'd0, 1'b0, b4} + {16'd0, c4};
            check({co4, s4} == e[4:0], "R1/R7 w4", {27'd0, co4, s4}, {27'd0, e[4:0]});
        end
        // exhaustive WIDTH=5 (chain ends on even cell, carry restored): R7
        for (int i = 0; i < 2048; i++) begin
            @(negedge clk);
            {c5, a5, b5} = 11'(i);
            #1;
            e = {11'd0, 1'b0, a5} + {11'd0, 1'b0, b5} + {16'd0, c5};
            check({co5, s5} == e[5:0], "R7 w5", {26'd0, co5, s5}, {26'd0, e[5:0]});
        end

        // directed WIDTH=16 corners
        run16(16'hFFFF, 16'h0000, 1'b0, "R5");          // full propagate, no carry
        check(s16 == 16'hFFFF && co16 == 1'b0, "R5", {15'd0, co16, s16}, 32'h0000FFFF);
        run16(16'hFFFF, 16'h0000, 1'b1, "R5");          // full ripple to the top
        check(s16 == 16'h0000 && co16 == 1'b1, "R5", {15'd0, co16, s16}, 32'h00010000);
        run16(16'h5555, 16'hAAAA, 1'b1, "R5");
        run16(16'h0001, 16'h0001, 1'b0, "R3");          // generate at bit 0 -> 2
        check(s16 == 16'h0002, "R3", {16'd0, s16}, 32'h2);
        run16(16'h8000, 16'h8000, 1'b1, "R3");          // generate at top bit
        check(co16 == 1'b1 && s16 == 16'h0001, "R3", {15'd0, co16, s16}, 32'h00010001);
        run16(16'h0F0F, 16'h0000, 1'b1, "R4");          // carry killed at bit 4
        check(s16 == 16'h0F10, "R4", {16'd0, s16}, 32'h0F10);
        run16(16'h0000, 16'h0000, 1'b1, "R4");          // all delete
        check(s16 == 16'h0001 && co16 == 1'b0, "R4", {15'd0, co16, s16}, 32'h1);
        run16(16'hFFFF, 16'hFFFF, 1'b1, "R6");          // all generate
        run16(16'h1234, 16'hEDCB, 1'b0, "R6");          // all propagate, mixed

        // seeded random WIDTH=16: R1, R8
        void'($urandom(32'd466));
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] x, y;
            x = 16'($urandom());
            y = 16'($urandom());
            if (i % 8 == 0) y = ~x;                     // propagate-heavy mix
            run16(x, y, 1'($urandom()), "R1");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule